// File: doc/BRIEF.md
# Thermometer-Based Leading Zero Counter

This block counts how many zero bits sit above the highest set bit of a 16-bit word. It is purely combinational and is meant to feed normalisation logic, where the count tells a later shifter how far to move a mantissa. The count is 5 bits wide so that it can express every value from 0 through 16.

The count is not built with a priority encoder. It is built in three stages:

- A bank of prefix-zero detectors reports, for each prefix length, whether that many top bits are all clear.
- A threshold stage turns those flags into a thermometer code whose bit k-1 means "the count is at least k".
- A range decoder turns the thermometer code into binary. Each binary bit is the OR of the intervals in which that bit is set.

The thermometer vector is also a port, so a neighbour can reuse it as a shift mask or observe it for debug.

The word width is a parameter and must be a power of two; an elaboration-time check enforces this. A second parameter selects how the thermometer stage is built:

- Threshold comparisons against a population count of the prefix flags.
- A cumulative AND chain.

Both variants give identical results.

Top module: `lzc_thermo`

## Requirements
- R1: Bit 15 of `din` is the most significant bit. `lz_count` equals the number of consecutive zero bits counted from bit 15 downward, stopping at the first one.
- R2: `thermo[k-1]` is 1 exactly when input bits 15 down to 16-k are all zero, for every k from 1 to 16.
- R3: An all-zero input gives `lz_count` = 16 and `thermo` = 16'hFFFF.
- R4: The thermometer output is monotone: if `thermo[k]` is 1 then `thermo[j]` is 1 for every j < k.
- R5: In the count, bit 4 equals `thermo[15]` and bit 3 is set exactly for counts 8 to 15. Bit 2 is set exactly for counts 4–7 and 12–15. Bit 1 is set for counts 2, 3, 6, 7, 10, 11, 14 and 15. Bit 0 is set for odd counts.
- R6: `lz_count` equals the number of ones in `thermo`.
- R7: Any input with bit 15 set gives `lz_count` = 0 and `thermo` = 0.
- R8: The outputs follow a change of `din` with no clock edge. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | 16 | Word to scan; bit 15 is scanned first |
| lz_count | output | 5 | Number of leading zeros, 0 to 16 |
| thermo | output | 16 | Thermometer code; bit k-1 set when the count is at least k |

## Verification
The bench builds the default 16-bit instance, which uses the population-count threshold stage, and sweeps every one of its 65536 input values. This covers every count from 0 to 16 and every range boundary of the decoder. A second instance is built 8 bits wide with the AND-chain threshold variant and is swept over all 256 values. This exercises the generic range-decoder generation at a different width and the other generate branch. Seeded random words and directed single-bit and all-zero patterns are added on top of the sweeps.

// File: rtl/lzc_thermo_pkg.sv
package lzc_thermo_pkg;

   // Construction variant of the thermometer stage
   typedef enum logic [0:0] {
      THR_POPCOUNT = 1'b0,   // compare a popcount of prefix flags against each k
      THR_CHAIN    = 1'b1    // cumulative AND along the prefix flags
   } thr_style_e;

   // The range decoder needs a power-of-two width
   function automatic bit is_pow2(int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   // Width of a count that spans 0..w inclusive
   function automatic int unsigned cnt_width(int unsigned w);
      return $clog2(w) + 1;
   endfunction

endpackage

// File: rtl/lzc_prefix_zero.sv
module lzc_prefix_zero #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] pz_vec   // pz_vec[k-1]: top k bits all zero
);

   for (genvar k = 1; k <= W; k++) begin : g_pz
      assign pz_vec[k-1] = ~|din[W-1 -: k];
   end

   // A longer all-zero prefix implies every shorter one (R2)
   always_comb begin
      assert_prefix_nested_R2: assert (((pz_vec >> 1) & ~pz_vec) == '0)
         else $error("prefix flags not nested");
   end

endmodule

// File: rtl/lzc_threshold.sv
module lzc_threshold
   import lzc_thermo_pkg::*;
#(
   parameter int unsigned W     = 16,
   parameter thr_style_e  STYLE = THR_POPCOUNT
) (
   input  logic [W-1:0] pz_vec,
   output logic [W-1:0] ge_vec    // ge_vec[k-1]: count is at least k
);

   localparam int unsigned PCW = $clog2(W + 1);

   if (STYLE == THR_POPCOUNT) begin : g_pop
      logic [PCW-1:0] pop;
      always_comb begin
         pop = '0;
         for (int i = 0; i < W; i++) pop = pop + PCW'(pz_vec[i]);
      end
      for (genvar k = 1; k <= W; k++) begin : g_thr
         assign ge_vec[k-1] = (pop >= PCW'(k));
      end
   end else begin : g_chain
      assign ge_vec[0] = pz_vec[0];
      for (genvar k = 1; k < W; k++) begin : g_and
         assign ge_vec[k] = ge_vec[k-1] & pz_vec[k];
      end
   end

   // Thermometer code must have no holes (R4)
   always_comb begin
      assert_thermo_monotone_R4: assert (((ge_vec >> 1) & ~ge_vec) == '0)
         else $error("thermometer code not monotone");
   end

endmodule

// File: rtl/lzc_range_decode.sv
module lzc_range_decode
   import lzc_thermo_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0]              ge_vec,
   output logic [cnt_width(W)-1:0]   cnt
);

   localparam int unsigned CW = cnt_width(W);

   // Top bit: every bit of the word was zero
   assign cnt[CW-1] = ge_vec[W-1];

   // Lower bit b is set over intervals [s, s+2^b-1], s = m*2^(b+1) + 2^b
   for (genvar b = 0; b < CW - 1; b++) begin : g_bit
      localparam int unsigned HALF = 1 << b;
      localparam int unsigned STEP = 1 << (b + 1);
      localparam int unsigned NT   = W / STEP;
      logic [NT-1:0] terms;
      for (genvar m = 0; m < NT; m++) begin : g_term
         localparam int unsigned S = m * STEP + HALF;
         assign terms[m] = ge_vec[S-1] & ~ge_vec[S+HALF-1];
      end
      assign cnt[b] = |terms;
   end

   // Binary value must equal the thermometer weight (R6)
   always_comb begin
      assert_count_weight_R6: assert (int'(cnt) == $countones(ge_vec))
         else $error("count differs from thermometer weight");
   end

endmodule

// File: rtl/lzc_thermo.sv
module lzc_thermo
   import lzc_thermo_pkg::*;
#(
   parameter int unsigned W     = 16,
   parameter thr_style_e  STYLE = THR_POPCOUNT,
   localparam int unsigned CW   = cnt_width(W)
) (
   input  logic [W-1:0]  din,
   output logic [CW-1:0] lz_count,
   output logic [W-1:0]  thermo
);

   if (!is_pow2(W)) begin : g_bad_width
      $error("lzc_thermo: W must be a power of two, at least 2");
   end

   logic [W-1:0] pz_vec;

   lzc_prefix_zero #(.W(W)) u_prefix (
      .din    (din),
      .pz_vec (pz_vec)
   );

   lzc_threshold #(.W(W), .STYLE(STYLE)) u_thr (
      .pz_vec (pz_vec),
      .ge_vec (thermo)
   );

   lzc_range_decode #(.W(W)) u_dec (
      .ge_vec (thermo),
      .cnt    (lz_count)
   );

   always_comb begin
      // The bit just below the zero run is a one (R1)
      if (int'(lz_count) < W) begin
         assert_first_one_R1: assert (din[W-1-int'(lz_count)] == 1'b1)
            else $error("bit below the zero run is not set");
      end
      // Full count exactly for the all-zero word (R3)
      assert_all_zero_R3: assert ((int'(lz_count) == W) == (din == '0))
         else $error("full count does not match all-zero input");
   end

endmodule

// File: tb/lzc_thermo_tb.sv
`timescale 1ns/1ps
module lzc_thermo_tb;
   import lzc_thermo_pkg::*;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   logic [15:0] din = '0;
   logic [4:0]  lz_count;
   logic [15:0] thermo;

   logic [7:0]  din8 = '0;
   logic [3:0]  lz_count8;
   logic [7:0]  thermo8;

   lzc_thermo #(.W(16), .STYLE(THR_POPCOUNT)) u_dut (
      .din(din), .lz_count(lz_count), .thermo(thermo));

   lzc_thermo #(.W(8), .STYLE(THR_CHAIN)) u_dut8 (
      .din(din8), .lz_count(lz_count8), .thermo(thermo8));

   function automatic int ref_clz(logic [15:0] v, int w);
      for (int i = w - 1; i >= 0; i--) if (v[i]) return w - 1 - i;
      return w;
   endfunction

   function automatic logic [15:0] ref_thermo(int c);
      logic [15:0] t = '0;
      for (int k = 1; k <= 16; k++) if (c >= k) t[k-1] = 1'b1;
      return t;
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check16(logic [15:0] v, string req);
      int c;
      @(posedge clk);
      din = v;
      @(negedge clk);
      c = ref_clz(v, 16);
      check(int'(lz_count) == c, {req, " count"}, lz_count, c);
      check(thermo == ref_thermo(c), {req, " thermo"}, thermo, ref_thermo(c));
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] rv;
      int c;
      void'($urandom(32'd20250611));

      // R3: all-zero word
      check16(16'h0000, "R3");
      check(lz_count == 5'd16, "R3 full", lz_count, 16);

      // R7: top bit set
      check16(16'h8000, "R7");
      check16(16'hFFFF, "R7");
      check(thermo == 16'h0000, "R7 thermo clear", thermo, 0);

      // R2/R5: single set bit at each position
      for (int i = 0; i < 16; i++) check16(16'h1 << i, "R2 R5 single");

      // R8: combinational response without a clock edge
      @(negedge clk);
      din = 16'h0010;
      #0.5;
      check(lz_count == 5'd11, "R8 no clock", lz_count, 11);
      din = 16'h0400;
      #0.5;
      check(lz_count == 5'd5, "R8 no clock", lz_count, 5);

      // R1/R4/R5/R6: exhaustive sweep of the 16-bit instance
      for (int v = 0; v < 65536; v++) begin
         @(posedge clk);
         din = 16'(v);
         @(negedge clk);
         c = ref_clz(16'(v), 16);
         check(int'(lz_count) == c, "R1 R5 sweep", lz_count, c);
         check(thermo == ref_thermo(c), "R2 R4 sweep", thermo, ref_thermo(c));
         check($countones(thermo) == int'(lz_count), "R6 sweep",
               $countones(thermo), lz_count);
      end

      // R1: seeded random words
      for (int n = 0; n < 2000; n++) begin
         rv = 16'($urandom);
         rv = rv >> ($urandom % 17);
         check16(rv, "R1 random");
      end

      // R1/R4: 8-bit chain variant, exhaustive
      for (int v = 0; v < 256; v++) begin
         @(posedge clk);
         din8 = 8'(v);
         @(negedge clk);
         c = ref_clz({8'h00, 8'(v)}, 8);
         check(int'(lz_count8) == c, "R1 w8", lz_count8, c);
         check(thermo8 == ref_thermo(c)[7:0], "R4 w8", thermo8,
               ref_thermo(c)[7:0]);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule